// File: doc/BRIEF.md
# Lockable Four-Way Cache Victim Selector

This block decides which way of a four-way set-associative cache receives the next linefill. Software can lock any subset of the ways through a coprocessor-style register port. A locked way is kept out of normal allocation, so code or data placed there stays resident. The data cache and the instruction cache each have their own lock register and their own replacement state.

Each side keeps a 2-bit round-robin pointer. On a fill request the block scans the ways upward from that pointer, wrapping at the top, and takes the first unlocked way. The pointer then moves to the way just above the victim. The result is a registered one-hot way selection with a valid flag, available one cycle after the request. If software locks all four ways, every fill goes to way 3 and the pointer does not move. Only three ways are meant to be locked, so normal replacement always has a way to use.

The lock registers sit at register number 9 with CRm equal to 0. The opcode2 field picks the side. Reads return the four lock bits. The cache arrays, tag compare and linefill bus sequencing live elsewhere.

Top module: `lockable_victim_sel`

## Requirements
- R1: After a synchronous active-low reset, both lock registers read 0, both round-robin pointers are 0, `way_valid` is 0 and `way_sel` is 0.
- R2: A register write (`reg_en`=1, `reg_wr`=1) with `reg_num`=9, `reg_crm`=0 and `reg_opc2`=0 loads `reg_wdata[3:0]` into the data-side lock register. With `reg_opc2`=1 it loads the instruction-side lock register. Bit i locks way i.
- R3: A register read (`reg_en`=1, `reg_wr`=0) at a matching address returns the selected side's lock bits on `reg_rdata[3:0]` in the same cycle, with bits [31:4] at 0. For any cycle that is not such a read, `reg_rdata` is 0.
- R4: An access with any other `reg_num`, any other `reg_crm`, or `reg_opc2` from 2 to 7 leaves both lock registers unchanged.
- R5: When `fill_req` is 1 at a clock edge, `way_valid` is 1 after that edge and `way_sel` is one-hot (bit i = way i). When `fill_req` is 0, both outputs are 0 after the edge.
- R6: If at least one way of the requesting side is unlocked, the selected way is never a locked one.
- R7: The victim is the first unlocked way found by scanning upward from that side's pointer, wrapping from way 3 to way 0. After the fill, the pointer becomes (victim + 1) mod 4.
- R8: When all four lock bits of the requesting side are 1, `way_sel` is 4'b1000 and that side's pointer is unchanged.
- R9: `fill_side`=0 selects the data side and `fill_side`=1 selects the instruction side. A fill uses and advances only the lock register and pointer of its own side.
- R10: A lock write in the same cycle as a fill request does not affect that fill. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_num | input | 4 | Coprocessor register number |
| reg_crm | input | 4 | CRm field of the access |
| reg_opc2 | input | 3 | Opcode2 field: 0 = data side, 1 = instruction side |
| reg_wdata | input | 4 | Lock bits to write |
| reg_rdata | output | 32 | Read data, zero when not reading a lock register |
| fill_req | input | 1 | Linefill allocation request |
| fill_side | input | 1 | 0 = data cache, 1 = instruction cache |
| way_valid | output | 1 | Way selection valid, one cycle after the request |
| way_sel | output | 4 | One-hot selected way |

## Verification
The assertions check on every cycle that:
- a valid selection is one-hot, and an idle output is all zero;
- a request is always followed by a valid selection;
- a selection never lands on a locked way while an unlocked one exists;
- a fully locked side yields way 3;
- the upper read-data bits stay zero.

Only the bench's scenarios can show the rest, because each needs a reference model carried over many operations:
- the round-robin order and how it skips locked ways;
- that the pointer holds when every way is locked;
- that each side is independent of the other;
- the write-versus-fill timing in a shared cycle;
- that writes to non-matching addresses are ignored.

// File: rtl/victim_sel_pkg.sv
// Package: shared types and constants for the lockable victim selector.
// Assumes the way count is a power of two so that pointer wrap is a plain truncation.
package victim_sel_pkg;

    typedef enum logic {
        SIDE_DATA  = 1'b0,
        SIDE_INSTR = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/lock_reg_bank.sv
// Module: lock_reg_bank
// Holds one lock register per cache side and decodes the coprocessor-style access.
// Assumes a single-cycle access: the write lands at the clock edge and the read is combinational.
module lock_reg_bank #(
    parameter int NUM_WAYS = 4,
    parameter int DATA_W   = 32,
    parameter int REG_NUM  = 9,
    parameter int REG_CRM  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_en,
    input  logic                reg_wr,
    input  logic [3:0]          reg_num,
    input  logic [3:0]          reg_crm,
    input  logic [2:0]          reg_opc2,
    input  logic [NUM_WAYS-1:0] reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_WAYS-1:0] lock_data,
    output logic [NUM_WAYS-1:0] lock_instr
);
    import victim_sel_pkg::*;

    localparam int PAD_W = DATA_W - NUM_WAYS;

    logic  addr_hit;
    side_e acc_side;

    // Address decode: register number, CRm, and an opcode2 value of 0 or 1.
    always_comb begin
        addr_hit = reg_en && (reg_num == 4'(REG_NUM)) && (reg_crm == 4'(REG_CRM))
                   && (reg_opc2[2:1] == 2'b00);
        acc_side = side_e'(reg_opc2[0]);
    end

    // Lock register update on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_data  <= '0;
            lock_instr <= '0;
        end else if (addr_hit && reg_wr) begin
            if (acc_side == SIDE_DATA) lock_data  <= reg_wdata;
            else                       lock_instr <= reg_wdata;
        end
    end

    // Read-back mux: lock bits on a decoded read, zero otherwise.
    always_comb begin
        reg_rdata = '0;
        if (addr_hit && !reg_wr)
            reg_rdata = {{PAD_W{1'b0}}, (acc_side == SIDE_DATA) ? lock_data : lock_instr};
    end

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_WAYS] == '0);  // R3

endmodule

// File: rtl/rr_way_picker.sv
// Module: rr_way_picker
// Round-robin victim choice among the unlocked ways of one cache side.
// Assumes NUM_WAYS is a power of two. When every way is locked, the last way is chosen and the pointer holds.
module rr_way_picker #(
    parameter int NUM_WAYS = 4,
    parameter int PTR_W    = $clog2(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAYS-1:0] lock,
    input  logic                fill,
    output logic [NUM_WAYS-1:0] victim_oh
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] pick;
    logic [PTR_W-1:0] idx;
    logic             found;

    // Scan from the pointer upward; a lower scan offset overrides a higher one.
    always_comb begin
        pick  = PTR_W'(NUM_WAYS - 1);
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            idx = ptr_q + PTR_W'(i);
            if (!lock[idx]) begin
                pick  = idx;
                found = 1'b1;
            end
        end
        victim_oh = '0;
        victim_oh[pick] = 1'b1;
    end

    // Pointer advance to the way above the victim, only when an unlocked way was found.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (fill && found)  ptr_q <= pick + PTR_W'(1);
    end

    AST_PICK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lock) |-> ((victim_oh & lock) == '0));  // R6

endmodule

// File: rtl/lockable_victim_sel.sv
// Module: lockable_victim_sel (top)
// Selects the linefill way for a data or instruction cache, honouring per-way lock bits.
// Assumes one request per cycle at most. The one-hot result is registered and valid one cycle later.
module lockable_victim_sel #(
    parameter int NUM_WAYS = 4,
    parameter int DATA_W   = 32,
    parameter int REG_NUM  = 9,
    parameter int REG_CRM  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_en,
    input  logic                reg_wr,
    input  logic [3:0]          reg_num,
    input  logic [3:0]          reg_crm,
    input  logic [2:0]          reg_opc2,
    input  logic [NUM_WAYS-1:0] reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                fill_req,
    input  logic                fill_side,
    output logic                way_valid,
    output logic [NUM_WAYS-1:0] way_sel
);
    import victim_sel_pkg::*;

    logic [NUM_WAYS-1:0] lock_data;
    logic [NUM_WAYS-1:0] lock_instr;
    logic [NUM_WAYS-1:0] side_lock [NUM_SIDES];
    logic [NUM_WAYS-1:0] side_victim [NUM_SIDES];
    logic [NUM_WAYS-1:0] req_lock;

    lock_reg_bank #(
        .NUM_WAYS(NUM_WAYS), .DATA_W(DATA_W), .REG_NUM(REG_NUM), .REG_CRM(REG_CRM)
    ) u_locks (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_num(reg_num), .reg_crm(reg_crm), .reg_opc2(reg_opc2),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lock_data(lock_data), .lock_instr(lock_instr)
    );

    // Route each side's lock register to its picker.
    always_comb begin
        side_lock[SIDE_DATA]  = lock_data;
        side_lock[SIDE_INSTR] = lock_instr;
        req_lock              = side_lock[fill_side];
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        rr_way_picker #(.NUM_WAYS(NUM_WAYS)) u_pick (
            .clk(clk), .rst_n(rst_n),
            .lock(side_lock[s]),
            .fill(fill_req && (fill_side == 1'(s))),
            .victim_oh(side_victim[s])
        );
    end

    // Output register: capture the requesting side's victim, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_valid <= 1'b0;
            way_sel   <= '0;
        end else begin
            way_valid <= fill_req;
            way_sel   <= fill_req ? side_victim[fill_side] : '0;
        end
    end

    AST_VALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        way_valid |-> ($countones(way_sel) == 1));  // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !way_valid |-> (way_sel == '0));  // R5
    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> way_valid);  // R5
    AST_SKIP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !(&req_lock)) |=> ((way_sel & $past(req_lock)) == '0));  // R6
    AST_ALL_LOCKED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && (&req_lock)) |=> (way_sel == {1'b1, {(NUM_WAYS-1){1'b0}}}));  // R8

endmodule

// File: tb/tb_lockable_victim_sel.sv
module tb_lockable_victim_sel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_en, reg_wr;
    logic [3:0]  reg_num, reg_crm;
    logic [2:0]  reg_opc2;
    logic [3:0]  reg_wdata;
    logic [31:0] reg_rdata;
    logic        fill_req, fill_side;
    logic        way_valid;
    logic [3:0]  way_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [3:0] lock_m [2];
    int         ptr_m  [2];

    lockable_victim_sel dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_num(reg_num), .reg_crm(reg_crm), .reg_opc2(reg_opc2),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fill_req(fill_req), .fill_side(fill_side),
        .way_valid(way_valid), .way_sel(way_sel)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic bit addr_hit(logic [3:0] n, logic [3:0] c, logic [2:0] o);
        return (n == 4'd9) && (c == 4'd0) && (o <= 3'd1);
    endfunction

    function automatic int exp_pick(logic [3:0] lk, int p);
        for (int i = 0; i < 4; i++) begin
            if (!lk[(p + i) % 4]) return (p + i) % 4;
        end
        return -1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_en = 0; reg_wr = 0; reg_num = 0; reg_crm = 0; reg_opc2 = 0; reg_wdata = 0;
        fill_req = 0; fill_side = 0;
    endtask

    // Write at a negedge; the register updates at the following posedge.
    task automatic reg_write(logic [3:0] n, logic [3:0] c, logic [2:0] o, logic [3:0] d);
        reg_en = 1; reg_wr = 1; reg_num = n; reg_crm = c; reg_opc2 = o; reg_wdata = d;
        @(negedge clk);
        if (addr_hit(n, c, o)) lock_m[o[0]] = d;
        idle_inputs();
    endtask

    task automatic reg_read(string req, logic [3:0] n, logic [3:0] c, logic [2:0] o);
        logic [31:0] e;
        reg_en = 1; reg_wr = 0; reg_num = n; reg_crm = c; reg_opc2 = o;
        #2;
        e = addr_hit(n, c, o) ? {28'b0, lock_m[o[0]]} : 32'h0;
        check(req, reg_rdata, e);
        @(negedge clk);
        idle_inputs();
    endtask

    // Apply a fill request at a negedge and check the registered result one negedge later.
    task automatic fill(string req, bit side);
        int v;
        logic [3:0] e;
        fill_req = 1; fill_side = side;
        v = exp_pick(lock_m[side], ptr_m[side]);
        if (v < 0) e = 4'b1000;
        else begin
            e = 4'(1 << v);
            ptr_m[side] = (v + 1) % 4;
        end
        @(negedge clk);
        idle_inputs();
        check(req, {31'b0, way_valid}, 32'd1);
        check(req, {28'b0, way_sel}, {28'b0, e});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rst_n = 0;
        lock_m[0] = 0; lock_m[1] = 0; ptr_m[0] = 0; ptr_m[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 way_valid", {31'b0, way_valid}, 0);
        check("R1 way_sel", {28'b0, way_sel}, 0);
        reg_read("R1 data lock", 4'd9, 4'd0, 3'd0);
        reg_read("R1 instr lock", 4'd9, 4'd0, 3'd1);

        // R7 plain round robin on data side: ways 0,1,2,3,0
        for (int i = 0; i < 5; i++) fill("R7 rr unlocked", 1'b0);
        // R5 idle cycle clears outputs
        @(negedge clk);
        check("R5 idle valid", {31'b0, way_valid}, 0);
        check("R5 idle sel", {28'b0, way_sel}, 0);

        // R9 instruction side starts from its own pointer 0
        fill("R9 instr own ptr", 1'b1);

        // R2/R3 write and read back each side
        reg_write(4'd9, 4'd0, 3'd0, 4'b0101);
        reg_write(4'd9, 4'd0, 3'd1, 4'b0010);
        reg_read("R2 R3 data lock", 4'd9, 4'd0, 3'd0);
        reg_read("R2 R3 instr lock", 4'd9, 4'd0, 3'd1);

        // R6 R7 skipping locked ways
        for (int i = 0; i < 4; i++) fill("R6 R7 skip locked data", 1'b0);
        for (int i = 0; i < 4; i++) fill("R6 R9 skip locked instr", 1'b1);

        // R4 ignored addresses
        reg_write(4'd8, 4'd0, 3'd0, 4'b1111);
        reg_write(4'd9, 4'd1, 3'd0, 4'b1111);
        reg_write(4'd9, 4'd0, 3'd2, 4'b1111);
        reg_read("R4 data unchanged", 4'd9, 4'd0, 3'd0);
        reg_read("R4 instr unchanged", 4'd9, 4'd0, 3'd1);
        reg_read("R3 nonmatching read zero", 4'd9, 4'd0, 3'd5);

        // R8 all locked: way 3, pointer holds
        reg_write(4'd9, 4'd0, 3'd0, 4'b1111);
        fill("R8 all locked", 1'b0);
        fill("R8 all locked again", 1'b0);
        reg_write(4'd9, 4'd0, 3'd0, 4'b0000);
        fill("R8 pointer held", 1'b0);

        // R10 write in same cycle as fill: fill uses old lock
        reg_en = 1; reg_wr = 1; reg_num = 9; reg_crm = 0; reg_opc2 = 0;
        reg_wdata = 4'(1 << ptr_m[0]);
        fill("R10 same-cycle write ignored", 1'b0);
        lock_m[0] = 4'(1 << ((ptr_m[0] + 3) % 4));
        fill("R10 write applies next", 1'b0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 3) begin
                if ($urandom_range(0, 3) != 0)
                    reg_write(4'd9, 4'd0, 3'($urandom_range(0, 1)), 4'($urandom_range(0, 15)));
                else
                    reg_write(4'($urandom_range(0, 15)), 4'($urandom_range(0, 1)),
                              3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)));
            end else if (op < 4) begin
                reg_read("R3 R4 random read", 4'd9, 4'd0, 3'($urandom_range(0, 2)));
            end else begin
                fill("R6 R7 R9 random fill", 1'($urandom_range(0, 1)));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule